// File: doc/BRIEF.md
# Quantized SiLU activation unit

This block applies an integer-only approximation of the SiLU activation (x times the logistic sigmoid of x) to a stream of signed 8-bit quantized samples. It uses no table. The input axis is split into four regions. Below a negative threshold the output is clamped to zero. Between that threshold and zero a cubic polynomial is used. Between zero and the positive threshold a second cubic is used. Above the positive threshold the input passes through a linear identity. All constants are powers of two, derived from two scale exponents, so the datapath needs only multipliers, adders and shifters.

Three run-time settings shape the curve. The input scale exponent `nx` gives the input scale 2^-nx. The output scale exponent `ny` gives the output scale 2^-ny. The zero-point `zy` is added to every non-clamped result. The unit is fed with one sample per cycle together with a valid flag. It returns one saturated 8-bit result per accepted sample, in order, with its own valid flag. There is no backpressure.

The settings are taken from the configuration ports only while the first two pipeline stages are empty. Once a sample is inside the pipeline, the settings stay frozen until the pipeline drains.

Top module: `qsilu_act`

## Requirements
- R1: Every sample accepted with `in_valid` high at a rising edge comes out with `out_valid` high after the third rising edge, counting the accepting edge as the first. Samples come out in order, one per cycle, and `out_valid` is low in every other cycle.
- R2: Let T = 4 << nx. A sample x < -T produces exactly 0, with no zero-point added.
- R3: A sample x > T produces x scaled by 2^(ny-nx), plus zy, then saturated. The scaling follows the shift rule of R6.
- R4: A sample with -T <= x <= 0 produces (x + T)^2 · x, scaled by 2^(ny - 3·nx - 5) and added to zy.
- R5: A sample with 0 < x <= T produces (C3 - (x - T)^2) · x, scaled by 2^(ny - 3·nx - 5) and added to zy, where C3 = 1 << (2·nx + 5).
- R6: A scale exponent e >= 0 is applied as a left shift by e. A negative e is applied as an arithmetic right shift by |e|, after first adding 2^(|e|-1). This rounds halves toward plus infinity.
- R7: The input 0 belongs to the region of R4 and produces exactly zy.
- R8: Every non-clamped result saturates to [-128, 127] after the zero-point is added.
- R9: A synchronous reset clears all valid flags. After reset, `out_valid` and `out_data` are 0.
- R10: `cfg_nx`, `cfg_ny` and `cfg_zy` are captured only at an edge where pipeline stages one and two hold no valid sample. At every other edge, changes on these ports are ignored. This applies both to samples already in flight and to samples accepted before the pipeline drains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample on `in_data` is accepted at this edge |
| in_data | input | 8 | Signed quantized input sample |
| cfg_nx | input | 2 | Input scale exponent, 0 to 3 |
| cfg_ny | input | 3 | Output scale exponent, 0 to 7 |
| cfg_zy | input | 8 | Signed output zero-point |
| out_valid | output | 1 | `out_data` holds a result |
| out_data | output | 8 | Signed saturated quantized output |

## Verification
The bench builds the unit with its default widths: an 8-bit sample, a 2-bit `nx` and a 3-bit `ny`. At these widths every input code can be swept back to back under all 32 exponent pairs, with a spread of zero-points that includes both extremes. This reaches both thresholds, the zero input, every shift direction and rounding case, and both saturation limits. During each stream the bench changes the configuration ports after the first sample. All results are expected with the settings that were in effect when the stream began. A single isolated sample also pins the exact output latency.

// File: rtl/qsilu_pkg.sv
package qsilu_pkg;

    // Piecewise region of the activation curve.
    typedef enum logic [1:0] {
        RG_FLOOR = 2'd0,   // far negative: clamp to zero
        RG_NEG   = 2'd1,   // negative cubic, zero included
        RG_POS   = 2'd2,   // positive cubic
        RG_LIN   = 2'd3    // identity tail
    } region_e;

endpackage

// File: rtl/qsilu_region.sv
// Stage-one logic: picks the region and forms the threshold offset.
module qsilu_region
    import qsilu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NX_W   = 2,
    parameter int OFF_W  = 9
) (
    input  logic signed [DATA_W-1:0] x_i,
    input  logic        [NX_W-1:0]   nx_i,
    output region_e                  rg_o,
    output logic signed [OFF_W-1:0]  off_o
);

    logic signed [OFF_W-1:0] thr;
    logic signed [OFF_W-1:0] xe;

    always_comb begin
        thr   = OFF_W'(4) << nx_i;
        xe    = OFF_W'(x_i);
        rg_o  = RG_LIN;
        off_o = '0;
        if (xe < -thr) begin
            rg_o = RG_FLOOR;
        end else if (xe <= 0) begin
            rg_o  = RG_NEG;
            off_o = xe + thr;
        end else if (xe <= thr) begin
            rg_o  = RG_POS;
            off_o = xe - thr;
        end
    end

endmodule

// File: rtl/qsilu_poly.sv
// Stage-two logic: square of the offset and the cubic product.
module qsilu_poly
    import qsilu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NX_W   = 2,
    parameter int OFF_W  = 9,
    parameter int ACC_W  = 40
) (
    input  region_e                  rg_i,
    input  logic signed [DATA_W-1:0] x_i,
    input  logic signed [OFF_W-1:0]  off_i,
    input  logic        [NX_W-1:0]   nx_i,
    output logic signed [ACC_W-1:0]  prod_o
);

    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] oe;
    logic signed [ACC_W-1:0] sq;
    logic signed [ACC_W-1:0] c3;

    always_comb begin
        xe = ACC_W'(x_i);
        oe = ACC_W'(off_i);
        sq = oe * oe;
        c3 = ACC_W'(1) << (2 * int'(nx_i) + 5);
        unique case (rg_i)
            RG_NEG:   prod_o = sq * xe;
            RG_POS:   prod_o = (c3 - sq) * xe;
            RG_LIN:   prod_o = xe;
            default:  prod_o = '0;
        endcase
    end

endmodule

// File: rtl/qsilu_requant.sv
// Stage-three logic: power-of-two rescale, zero-point and saturation.
module qsilu_requant
    import qsilu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NX_W   = 2,
    parameter int NY_W   = 3,
    parameter int ACC_W  = 40
) (
    input  region_e                  rg_i,
    input  logic signed [ACC_W-1:0]  prod_i,
    input  logic        [NX_W-1:0]   nx_i,
    input  logic        [NY_W-1:0]   ny_i,
    input  logic signed [DATA_W-1:0] zy_i,
    output logic signed [DATA_W-1:0] y_o
);

    localparam logic signed [ACC_W-1:0] SAT_HI = (ACC_W'(1) << (DATA_W - 1)) - 1;
    localparam logic signed [ACC_W-1:0] SAT_LO = -(ACC_W'(1) << (DATA_W - 1));

    int                      sh;
    int                      rsh;
    logic signed [ACC_W-1:0] half;
    logic signed [ACC_W-1:0] scaled;
    logic signed [ACC_W-1:0] sum;

    always_comb begin
        if (rg_i == RG_LIN) sh = int'(ny_i) - int'(nx_i);
        else                sh = int'(ny_i) - 3 * int'(nx_i) - 5;
        rsh  = 0;
        half = '0;
        if (sh >= 0) begin
            scaled = prod_i <<< sh;
        end else begin
            rsh    = -sh;
            half   = ACC_W'(1) << (rsh - 1);
            scaled = (prod_i + half) >>> rsh;
        end
        sum = scaled + ACC_W'(zy_i);
        if (rg_i == RG_FLOOR)  y_o = '0;
        else if (sum > SAT_HI) y_o = SAT_HI[DATA_W-1:0];
        else if (sum < SAT_LO) y_o = SAT_LO[DATA_W-1:0];
        else                   y_o = sum[DATA_W-1:0];
    end

endmodule

// File: rtl/qsilu_act.sv
// Three-stage quantized SiLU datapath: region, cubic, requantize.
module qsilu_act
    import qsilu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NX_W   = 2,
    parameter int NY_W   = 3,
    parameter int ACC_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic        [NX_W-1:0]   cfg_nx,
    input  logic        [NY_W-1:0]   cfg_ny,
    input  logic signed [DATA_W-1:0] cfg_zy,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int NX_MAX = (1 << NX_W) - 1;
    localparam int THR_W  = NX_MAX + 4;
    localparam int OFF_W  = ((DATA_W > THR_W) ? DATA_W : THR_W) + 1;

    typedef struct packed {
        logic                     s1_vld;
        region_e                  s1_rg;
        logic signed [DATA_W-1:0] s1_x;
        logic signed [OFF_W-1:0]  s1_off;
        logic                     s2_vld;
        region_e                  s2_rg;
        logic signed [ACC_W-1:0]  s2_prod;
        logic                     o_vld;
        logic signed [DATA_W-1:0] o_y;
        logic        [NX_W-1:0]   nx;
        logic        [NY_W-1:0]   ny;
        logic signed [DATA_W-1:0] zy;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                     busy;
    logic        [NX_W-1:0]   nx_eff;
    region_e                  rg1;
    logic signed [OFF_W-1:0]  off1;
    logic signed [ACC_W-1:0]  prod2;
    logic signed [DATA_W-1:0] y3;

    // Signals brought out for the bound checker.
    logic                     s1_vld_w, s2_vld_w;
    logic        [NX_W-1:0]   nx_w;
    logic        [NY_W-1:0]   ny_w;
    logic signed [DATA_W-1:0] zy_w;

    assign busy   = st_q.s1_vld | st_q.s2_vld;
    assign nx_eff = busy ? st_q.nx : cfg_nx;

    qsilu_region #(
        .DATA_W (DATA_W),
        .NX_W   (NX_W),
        .OFF_W  (OFF_W)
    ) u_region (
        .x_i   (in_data),
        .nx_i  (nx_eff),
        .rg_o  (rg1),
        .off_o (off1)
    );

    qsilu_poly #(
        .DATA_W (DATA_W),
        .NX_W   (NX_W),
        .OFF_W  (OFF_W),
        .ACC_W  (ACC_W)
    ) u_poly (
        .rg_i   (st_q.s1_rg),
        .x_i    (st_q.s1_x),
        .off_i  (st_q.s1_off),
        .nx_i   (st_q.nx),
        .prod_o (prod2)
    );

    qsilu_requant #(
        .DATA_W (DATA_W),
        .NX_W   (NX_W),
        .NY_W   (NY_W),
        .ACC_W  (ACC_W)
    ) u_requant (
        .rg_i   (st_q.s2_rg),
        .prod_i (st_q.s2_prod),
        .nx_i   (st_q.nx),
        .ny_i   (st_q.ny),
        .zy_i   (st_q.zy),
        .y_o    (y3)
    );

    always_comb begin
        st_d = st_q;
        // Settings frozen while stages one or two hold a sample.
        st_d.nx = nx_eff;
        st_d.ny = busy ? st_q.ny : cfg_ny;
        st_d.zy = busy ? st_q.zy : cfg_zy;
        // Stage one
        st_d.s1_vld = in_valid;
        st_d.s1_rg  = rg1;
        st_d.s1_x   = in_data;
        st_d.s1_off = off1;
        // Stage two
        st_d.s2_vld  = st_q.s1_vld;
        st_d.s2_rg   = st_q.s1_rg;
        st_d.s2_prod = prod2;
        // Stage three
        st_d.o_vld = st_q.s2_vld;
        st_d.o_y   = st_q.s2_vld ? y3 : st_q.o_y;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.o_vld;
    assign out_data  = st_q.o_y;

    assign s1_vld_w = st_q.s1_vld;
    assign s2_vld_w = st_q.s2_vld;
    assign nx_w     = st_q.nx;
    assign ny_w     = st_q.ny;
    assign zy_w     = st_q.zy;

endmodule

// File: rtl/qsilu_act_chk.sv
// Checker bound to qsilu_act.
module qsilu_act_chk #(
    parameter int DATA_W = 8,
    parameter int NX_W   = 2,
    parameter int NY_W   = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_data,
    input logic                     s1_vld,
    input logic                     s2_vld,
    input logic        [NX_W-1:0]   nx,
    input logic        [NY_W-1:0]   ny,
    input logic signed [DATA_W-1:0] zy
);

    logic [2:0]               vh;
    logic signed [DATA_W-1:0] xh0, xh1, xh2;

    always_ff @(posedge clk) begin
        if (rst) vh <= '0;
        else     vh <= {vh[1:0], in_valid};
    end

    always_ff @(posedge clk) begin
        xh0 <= in_data;
        xh1 <= xh0;
        xh2 <= xh1;
    end

    // R1: result flag follows the accepted flag three edges later
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid == vh[2]);

    // R2: far-negative sample gives exactly zero
    p_floor_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (vh[2] && (int'(xh2) < -(4 << nx))) |-> (out_data == '0));

    // R7: zero input gives the zero-point
    p_zero_in_r7: assert property (@(posedge clk) disable iff (rst)
        (vh[2] && (xh2 == '0)) |-> (out_data == zy));

    // R10: settings hold while a sample occupies stage one or two
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (s1_vld || s2_vld) |=> ($stable(nx) && $stable(ny) && $stable(zy)));

    // R9: reset leaves no valid result
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

bind qsilu_act qsilu_act_chk #(
    .DATA_W (DATA_W),
    .NX_W   (NX_W),
    .NY_W   (NY_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .s1_vld    (s1_vld_w),
    .s2_vld    (s2_vld_w),
    .nx        (nx_w),
    .ny        (ny_w),
    .zy        (zy_w)
);

// File: tb/qsilu_act_tb_top.sv
module qsilu_act_tb_top;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_data = '0;
    logic        [1:0] cfg_nx = '0;
    logic        [2:0] cfg_ny = '0;
    logic signed [7:0] cfg_zy = '0;
    logic              out_valid;
    logic signed [7:0] out_data;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    exp;
        int    x;
        string tag;
    } exp_t;

    exp_t pend[$];

    always #10 clk = ~clk;

    qsilu_act dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_nx    (cfg_nx),
        .cfg_ny    (cfg_ny),
        .cfg_zy    (cfg_zy),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Arithmetic model written from the requirements.
    function automatic int model(input int x, input int nx, input int ny,
                                 input int zy, output string tag);
        longint t, p, s;
        int     sh;
        t = longint'(4) << nx;
        if (x < -t) begin
            tag = "R2";
            return 0;
        end
        if (x <= 0) begin
            p   = (x + t) * (x + t) * x;
            sh  = ny - 3 * nx - 5;
            tag = (x == 0) ? "R7 R4" : "R4";
        end else if (x <= t) begin
            p   = ((longint'(1) << (2 * nx + 5)) - (x - t) * (x - t)) * x;
            sh  = ny - 3 * nx - 5;
            tag = "R5";
        end else begin
            p   = x;
            sh  = ny - nx;
            tag = "R3";
        end
        if (sh >= 0) s = p <<< sh;
        else begin
            s   = (p + (longint'(1) << (-sh - 1))) >>> (-sh);
            tag = {tag, " R6"};
        end
        s = s + zy;
        if (s > 127) begin s = 127; tag = {tag, " R8"}; end
        else if (s < -128) begin s = -128; tag = {tag, " R8"}; end
        return int'(s);
    endfunction

    task automatic push(input int x, input int nx, input int ny, input int zy,
                        input string extra);
        exp_t  e;
        string tg;
        e.x   = x;
        e.exp = model(x, nx, ny, zy, tg);
        e.tag = {tg, extra};
        pend.push_back(e);
    endtask

    // Result monitor, away from the active edge.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (pend.size() == 0) begin
                errors++;
                $display("FAIL R1 unexpected result: got %0d, expected no result", out_data);
            end else begin
                exp_t e;
                e = pend.pop_front();
                if (int'(out_data) != e.exp) begin
                    errors++;
                    $display("FAIL %s x=%0d: got %0d, expected %0d",
                             e.tag, e.x, out_data, e.exp);
                end
            end
        end
    end

    // One stream of all input codes. The ports change after the first
    // sample; every result must use the settings captured with it (R10).
    task automatic run_cfg(input int nx, input int ny, input int zy);
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (i == 0) begin
                cfg_nx = 2'(nx);
                cfg_ny = 3'(ny);
                cfg_zy = 8'(zy);
            end else if (i == 1) begin
                cfg_nx = 2'(nx ^ 1);
                cfg_ny = 3'(ny ^ 3);
                cfg_zy = 8'(zy ^ 'h55);
            end
            in_valid = 1'b1;
            in_data  = 8'(i - 128);
            push(i - 128, nx, ny, zy, (i > 0) ? " R10" : "");
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_bit(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check_bit(out_valid, 1'b0, "R9 out_valid after reset");
        checks++;
        if (out_data !== 8'sd0) begin
            errors++;
            $display("FAIL R9 out_data after reset: got %0d, expected 0", out_data);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1: exact latency of an isolated sample (6 > T=4: linear, saturates)
        cfg_nx   = 2'd0;
        cfg_ny   = 3'd5;
        cfg_zy   = 8'sd3;
        in_valid = 1'b1;
        in_data  = 8'sd6;
        push(6, 0, 5, 3, " R1");
        @(negedge clk);
        in_valid = 1'b0;
        check_bit(out_valid, 1'b0, "R1 one edge after accept");
        @(negedge clk);
        check_bit(out_valid, 1'b0, "R1 two edges after accept");
        @(negedge clk);
        check_bit(out_valid, 1'b1, "R1 three edges after accept");
        repeat (3) @(negedge clk);

        // Full sweep over every exponent pair
        for (int nx = 0; nx < 4; nx++) begin
            for (int ny = 0; ny < 8; ny++) begin
                run_cfg(nx, ny, (((nx * 8 + ny) * 29) % 256) - 128);
            end
        end
        // Zero-point extremes for saturation (R8)
        run_cfg(0, 7, 127);
        run_cfg(0, 7, -128);
        run_cfg(3, 0, 127);
        run_cfg(3, 0, -128);

        repeat (4) @(negedge clk);
        checks++;
        if (pend.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results: got %0d pending, expected 0", pend.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule